// File: doc/BRIEF.md
# Sound Unit Register File with Master Power Control

This block sits between a processor's byte-wide bus and the four channel datapaths of a sound unit. It decodes a small offset window into per-channel register slots, a master output volume byte, a channel pan byte, a master power and status byte and a 16-byte wave-table window. It holds the readable bits of every channel register, so that read data comes back combinationally. It also produces per-channel write strobes that the channel datapaths consume.

Master power gates the rest of the window. While the unit is off, only the status byte and the wave window accept writes. In the first variant, a write to a channel's length slot still loads that channel's length counter. Turning power off clears every stored register and sends a clear pulse to the channels. Turning power on restarts the frame sequencer, and in the second variant it also resets all length counters. A write to a trigger slot carries a flag telling the channel whether an extra length clock applies. That flag is the inverse of the frame sequencer's current length phase.

Top module: `snd_regfile`

## Requirements
- R1: After reset the unit is off, the status byte at offset 0x16 reads 0x70 with the active inputs at zero, and volume (0x14) and pan (0x15) read 0x00.
- R2: The status byte reads power in bit 7, ones in bits 6:4 and `ch_active_i[3:0]` in bits 3:0, live.
- R3: Offsets with no readable bits read 0xFF: frequency-low slots (slot 3), the control slot of channels 1 to 3, offsets 0x17 to 0x1F and everything from 0x30 up.
- R4: The status byte and the wave window (0x20 to 0x2F, index = offset minus 0x20) accept writes whatever the power state; a wave write raises `wave_wr_o` with the index in the same cycle.
- R5: While off, writes to channel slots, volume and pan are ignored: `ch_wr_o` stays zero and the readback is unchanged.
- R6: In variant 0 (`variant_i`=0), a write to a length slot (slot 1) while off raises `len_load_o` for that channel only, with `ch_wr_o` zero.
- R7: In variant 1, a length-slot write while off raises no `len_load_o`.
- R8: A status write with bit 7 clear while on raises `ch_pwr_clr_o` in that cycle; afterwards volume, pan and every channel slot read back as their all-zero stored value.
- R9: A status write with bit 7 set while off raises `fs_restart_o` in that cycle, and raises `len_reset_o` only in variant 1.
- R10: A powered write to a trigger slot (slot 4) drives `trig_extra_o` to the inverse of `fs_len_phase_i`; other slots keep it low.
- R11: Channel c slot k sits at offset 5c+k. Powered writes store the data, and a read returns the stored bits ORed with a fixed mask of ones: 0x80 for channel 0 control, 0x3F for length, 0x00 for envelope (slot 2), 0xBF for trigger.
- R12: Reads in the wave window return `wave_rdata_i` combinationally, with `wave_rd_o` raised while `rd_en_i` is high.
- R13: A write takes effect at the clock edge: during the write cycle, the read data still shows the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset |
| variant_i | input | 1 | Hardware variant select (0 or 1) |
| addr_i | input | 8 | Byte offset into the window |
| wdata_i | input | 8 | Write data |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Combinational read data |
| ch_active_i | input | 4 | Channel active flags |
| fs_len_phase_i | input | 1 | Frame sequencer's current step clocks length |
| ch_wr_o | output | 4 | Per-channel accepted write strobe |
| ch_slot_o | output | 3 | Slot index of the write |
| ch_data_o | output | 8 | Data for channel writes |
| trig_extra_o | output | 1 | Extra length clock flag on trigger writes |
| len_load_o | output | 4 | Per-channel length load strobe |
| ch_pwr_clr_o | output | 1 | Power-off clear pulse to channels |
| len_reset_o | output | 1 | Length counter reset pulse at power-on |
| fs_restart_o | output | 1 | Frame sequencer restart pulse |
| wave_wr_o | output | 1 | Wave table write strobe |
| wave_rd_o | output | 1 | Wave table read strobe |
| wave_idx_o | output | 4 | Wave table byte index |
| wave_wdata_o | output | 8 | Wave table write data |
| wave_rdata_i | input | 8 | Wave table read data |
| pwr_on_o | output | 1 | Master power state |

## Verification
The bench builds the block with its defaults: four channels, an 8-bit offset and a 16-byte wave window at 0x20. These values put every decoded target within reach of byte offsets: all twenty channel slots, the three master bytes, the unmapped gap and the region above the wave window. Both variants can be switched at run time, so the length gating while off and the length reset at power-on are exercised in each variant within one run.

// File: rtl/snd_regs_pkg.sv
package snd_regs_pkg;

  localparam int unsigned SLOTS_PER_CH = 5;

  typedef enum logic [2:0] {
    SL_CTRL = 3'd0,
    SL_LEN  = 3'd1,
    SL_ENV  = 3'd2,
    SL_FLO  = 3'd3,
    SL_TRIG = 3'd4
  } slot_e;

  typedef enum logic [2:0] {
    TG_NONE,
    TG_CHAN,
    TG_VOL,
    TG_PAN,
    TG_STAT,
    TG_WAVE
  } tgt_e;

  typedef struct packed {
    tgt_e       tgt;
    logic [1:0] ch;
    slot_e      slot;
  } dec_t;

  // Bits that always read back as one for a given channel slot.
  function automatic logic [7:0] read_ones(input logic [1:0] ch, input slot_e sl);
    logic [7:0] m;
    case (sl)
      SL_CTRL: m = (ch == 2'd0) ? 8'h80 : 8'hFF;
      SL_LEN:  m = 8'h3F;
      SL_ENV:  m = 8'h00;
      SL_FLO:  m = 8'hFF;
      SL_TRIG: m = 8'hBF;
      default: m = 8'hFF;
    endcase
    return m;
  endfunction

  // Master status byte layout.
  function automatic logic [7:0] status_byte(input logic pwr, input logic [3:0] act);
    return {pwr, 3'b111, act};
  endfunction

endpackage

// File: rtl/snd_addr_decode.sv
module snd_addr_decode
  import snd_regs_pkg::*;
#(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned NUM_CH     = 4,
  parameter int unsigned WAVE_BASE  = 32,
  parameter int unsigned WAVE_BYTES = 16,
  localparam int unsigned WAVE_IW   = $clog2(WAVE_BYTES)
) (
  input  logic [ADDR_W-1:0]  addr_i,
  output dec_t               dec_o,
  output logic [WAVE_IW-1:0] wave_idx_o
);

  localparam int unsigned CH_SPAN  = NUM_CH * SLOTS_PER_CH;
  localparam int unsigned VOL_OFS  = CH_SPAN;
  localparam int unsigned PAN_OFS  = CH_SPAN + 1;
  localparam int unsigned STAT_OFS = CH_SPAN + 2;
  localparam int unsigned WAVE_END = WAVE_BASE + WAVE_BYTES;

  always_comb begin
    int unsigned a;
    a          = 32'(addr_i);
    dec_o      = '0;
    dec_o.tgt  = TG_NONE;
    wave_idx_o = '0;
    if (a < CH_SPAN) begin
      dec_o.tgt  = TG_CHAN;
      dec_o.ch   = 2'(a / SLOTS_PER_CH);
      dec_o.slot = slot_e'(3'(a % SLOTS_PER_CH));
    end else if (a == VOL_OFS) begin
      dec_o.tgt = TG_VOL;
    end else if (a == PAN_OFS) begin
      dec_o.tgt = TG_PAN;
    end else if (a == STAT_OFS) begin
      dec_o.tgt = TG_STAT;
    end else if (a >= WAVE_BASE && a < WAVE_END) begin
      dec_o.tgt  = TG_WAVE;
      wave_idx_o = WAVE_IW'(a - WAVE_BASE);
    end
  end

endmodule

// File: rtl/snd_power_ctrl.sv
module snd_power_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stat_wr_i,
  input  logic want_on_i,
  input  logic variant_i,
  output logic pwr_q_o,
  output logic off_ev_o,
  output logic on_ev_o,
  output logic len_rst_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        pwr_q_o <= 1'b0;
    else if (stat_wr_i) pwr_q_o <= want_on_i;
  end

  assign off_ev_o  = stat_wr_i &  pwr_q_o & ~want_on_i;
  assign on_ev_o   = stat_wr_i & ~pwr_q_o &  want_on_i;
  assign len_rst_o = on_ev_o & variant_i;

endmodule

// File: rtl/snd_chan_bank.sv
module snd_chan_bank
  import snd_regs_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  localparam int unsigned N_REG = NUM_CH * SLOTS_PER_CH
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic       clr_i,
  input  logic [1:0] ch_i,
  input  slot_e      slot_i,
  input  logic [7:0] data_i,
  output logic [7:0] rd_o
);

  logic [N_REG*8-1:0] view;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    for (genvar s = 0; s < SLOTS_PER_CH; s++) begin : g_slot
      localparam logic [7:0] ONES = read_ones(2'(c), slot_e'(3'(s)));
      logic [7:0] q;
      logic       hit;
      assign hit = wr_i && (ch_i == 2'(c)) && (slot_i == slot_e'(3'(s)));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)    q <= '0;
        else if (clr_i) q <= '0;
        else if (hit)   q <= data_i & ~ONES;
      end
      assign view[(c*SLOTS_PER_CH+s)*8 +: 8] = q | ONES;
    end
  end

  always_comb begin
    int unsigned idx;
    idx  = 32'(ch_i) * SLOTS_PER_CH + 32'(slot_i);
    rd_o = 8'hFF;
    for (int unsigned k = 0; k < N_REG; k++) begin
      if (k == idx) rd_o = view[k*8 +: 8];
    end
  end

endmodule

// File: rtl/snd_regfile.sv
module snd_regfile
  import snd_regs_pkg::*;
#(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned NUM_CH     = 4,
  parameter int unsigned WAVE_BASE  = 32,
  parameter int unsigned WAVE_BYTES = 16,
  localparam int unsigned WAVE_IW   = $clog2(WAVE_BYTES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               variant_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [7:0]         wdata_i,
  input  logic               wr_en_i,
  input  logic               rd_en_i,
  output logic [7:0]         rdata_o,
  input  logic [NUM_CH-1:0]  ch_active_i,
  input  logic               fs_len_phase_i,
  output logic [NUM_CH-1:0]  ch_wr_o,
  output logic [2:0]         ch_slot_o,
  output logic [7:0]         ch_data_o,
  output logic               trig_extra_o,
  output logic [NUM_CH-1:0]  len_load_o,
  output logic               ch_pwr_clr_o,
  output logic               len_reset_o,
  output logic               fs_restart_o,
  output logic               wave_wr_o,
  output logic               wave_rd_o,
  output logic [WAVE_IW-1:0] wave_idx_o,
  output logic [7:0]         wave_wdata_o,
  input  logic [7:0]         wave_rdata_i,
  output logic               pwr_on_o
);

  dec_t       dec;
  logic       stat_wr;
  logic       chan_hit;
  logic       chan_acc;
  logic       len_ok;
  logic       off_ev;
  logic       on_ev;
  logic [7:0] vol_q;
  logic [7:0] pan_q;
  logic [7:0] bank_rd;

  snd_addr_decode #(
    .ADDR_W(ADDR_W), .NUM_CH(NUM_CH),
    .WAVE_BASE(WAVE_BASE), .WAVE_BYTES(WAVE_BYTES)
  ) u_dec (
    .addr_i     (addr_i),
    .dec_o      (dec),
    .wave_idx_o (wave_idx_o)
  );

  assign stat_wr = wr_en_i && (dec.tgt == TG_STAT);

  snd_power_ctrl u_pwr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .stat_wr_i (stat_wr),
    .want_on_i (wdata_i[7]),
    .variant_i (variant_i),
    .pwr_q_o   (pwr_on_o),
    .off_ev_o  (off_ev),
    .on_ev_o   (on_ev),
    .len_rst_o (len_reset_o)
  );

  assign ch_pwr_clr_o = off_ev;
  assign fs_restart_o = on_ev;

  // Channel slot writes: full writes only when powered, length loads also
  // while off in variant 0.
  assign chan_hit = wr_en_i && (dec.tgt == TG_CHAN);
  assign chan_acc = chan_hit && pwr_on_o;
  assign len_ok   = chan_hit && (dec.slot == SL_LEN) && (pwr_on_o || !variant_i);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_strobe
    assign ch_wr_o[c]    = chan_acc && (dec.ch == 2'(c));
    assign len_load_o[c] = len_ok   && (dec.ch == 2'(c));
  end

  assign ch_slot_o    = dec.slot;
  assign ch_data_o    = wdata_i;
  assign trig_extra_o = chan_acc && (dec.slot == SL_TRIG) && !fs_len_phase_i;

  snd_chan_bank #(.NUM_CH(NUM_CH)) u_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (chan_acc),
    .clr_i  (off_ev),
    .ch_i   (dec.ch),
    .slot_i (dec.slot),
    .data_i (wdata_i),
    .rd_o   (bank_rd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vol_q <= '0;
      pan_q <= '0;
    end else if (off_ev) begin
      vol_q <= '0;
      pan_q <= '0;
    end else if (wr_en_i && pwr_on_o) begin
      if (dec.tgt == TG_VOL) vol_q <= wdata_i;
      if (dec.tgt == TG_PAN) pan_q <= wdata_i;
    end
  end

  assign wave_wr_o    = wr_en_i && (dec.tgt == TG_WAVE);
  assign wave_rd_o    = rd_en_i && (dec.tgt == TG_WAVE);
  assign wave_wdata_o = wdata_i;

  always_comb begin
    case (dec.tgt)
      TG_CHAN: rdata_o = bank_rd;
      TG_VOL:  rdata_o = vol_q;
      TG_PAN:  rdata_o = pan_q;
      TG_STAT: rdata_o = status_byte(pwr_on_o, 4'(ch_active_i));
      TG_WAVE: rdata_o = wave_rdata_i;
      default: rdata_o = 8'hFF;
    endcase
  end

endmodule

// File: rtl/snd_regfile_chk.sv
module snd_regfile_chk #(
  parameter int unsigned NUM_CH = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              variant_i,
  input logic              pwr_on_o,
  input logic [NUM_CH-1:0] ch_wr_o,
  input logic [NUM_CH-1:0] len_load_o,
  input logic              trig_extra_o,
  input logic              fs_len_phase_i,
  input logic              ch_pwr_clr_o,
  input logic              len_reset_o,
  input logic              fs_restart_o,
  input logic [7:0]        vol_q,
  input logic [7:0]        pan_q
);

  // R5: no channel write strobe while off
  a_r5_off_no_chan_wr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_on_o |-> ch_wr_o == '0);

  // R5: mix bytes hold zero for as long as power is off
  a_r5_off_mix_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_on_o |-> (vol_q == 8'h00 && pan_q == 8'h00));

  // R8: clear pulse leaves the unit off with mix bytes zero
  a_r8_off_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ch_pwr_clr_o |=> (!pwr_on_o && vol_q == 8'h00 && pan_q == 8'h00));

  // R9: restart pulse leads to the powered state
  a_r9_on_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fs_restart_o |=> pwr_on_o);

  // R9: length reset only in variant 1 and only with a restart
  a_r9_len_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    len_reset_o |-> (variant_i && fs_restart_o));

  // R7: variant 1 never loads length while off
  a_r7_v1_no_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (variant_i && !pwr_on_o) |-> len_load_o == '0);

  // R10: extra flag only with one accepted write and phase low
  a_r10_extra: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_extra_o |-> (!fs_len_phase_i && $onehot0(ch_wr_o) && ch_wr_o != '0));

endmodule

bind snd_regfile snd_regfile_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .variant_i      (variant_i),
  .pwr_on_o       (pwr_on_o),
  .ch_wr_o        (ch_wr_o),
  .len_load_o     (len_load_o),
  .trig_extra_o   (trig_extra_o),
  .fs_len_phase_i (fs_len_phase_i),
  .ch_pwr_clr_o   (ch_pwr_clr_o),
  .len_reset_o    (len_reset_o),
  .fs_restart_o   (fs_restart_o),
  .vol_q          (vol_q),
  .pan_q          (pan_q)
);

// File: tb/snd_regfile_tb.sv
module snd_regfile_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       variant = 1'b0;
  logic [7:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [7:0] rdata;
  logic [3:0] act = '0;
  logic       phase = 1'b1;
  logic [3:0] ch_wr;
  logic [2:0] ch_slot;
  logic [7:0] ch_data;
  logic       trig_extra;
  logic [3:0] len_load;
  logic       pwr_clr;
  logic       len_rst;
  logic       fs_rst;
  logic       wave_wr;
  logic       wave_rd;
  logic [3:0] wave_idx;
  logic [7:0] wave_wdata;
  logic [7:0] wave_rdata = '0;
  logic       pwr_on;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  snd_regfile u_dut (
    .clk_i(clk), .rst_ni(rst_n), .variant_i(variant),
    .addr_i(addr), .wdata_i(wdata), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .rdata_o(rdata), .ch_active_i(act), .fs_len_phase_i(phase),
    .ch_wr_o(ch_wr), .ch_slot_o(ch_slot), .ch_data_o(ch_data),
    .trig_extra_o(trig_extra), .len_load_o(len_load),
    .ch_pwr_clr_o(pwr_clr), .len_reset_o(len_rst), .fs_restart_o(fs_rst),
    .wave_wr_o(wave_wr), .wave_rd_o(wave_rd), .wave_idx_o(wave_idx),
    .wave_wdata_o(wave_wdata), .wave_rdata_i(wave_rdata), .pwr_on_o(pwr_on)
  );

  // {req tag, is write, offset, data, expected read}
  localparam int NV = 26;
  localparam logic [28:0] VEC [NV] = '{
    {4'd4,  1'b1, 8'h16, 8'h80, 8'h00},
    {4'd2,  1'b0, 8'h16, 8'h00, 8'hF0},
    {4'd11, 1'b1, 8'h14, 8'h77, 8'h00},
    {4'd11, 1'b0, 8'h14, 8'h00, 8'h77},
    {4'd11, 1'b1, 8'h15, 8'hAB, 8'h00},
    {4'd11, 1'b0, 8'h15, 8'h00, 8'hAB},
    {4'd11, 1'b1, 8'h00, 8'h12, 8'h00},
    {4'd11, 1'b0, 8'h00, 8'h00, 8'h92},
    {4'd11, 1'b1, 8'h01, 8'h45, 8'h00},
    {4'd11, 1'b0, 8'h01, 8'h00, 8'h7F},
    {4'd11, 1'b1, 8'h02, 8'hA3, 8'h00},
    {4'd11, 1'b0, 8'h02, 8'h00, 8'hA3},
    {4'd3,  1'b1, 8'h03, 8'h55, 8'h00},
    {4'd3,  1'b0, 8'h03, 8'h00, 8'hFF},
    {4'd11, 1'b1, 8'h04, 8'h07, 8'h00},
    {4'd11, 1'b0, 8'h04, 8'h00, 8'hBF},
    {4'd11, 1'b1, 8'h09, 8'h40, 8'h00},
    {4'd11, 1'b0, 8'h09, 8'h00, 8'hFF},
    {4'd3,  1'b1, 8'h05, 8'h12, 8'h00},
    {4'd3,  1'b0, 8'h05, 8'h00, 8'hFF},
    {4'd11, 1'b1, 8'h0C, 8'h5A, 8'h00},
    {4'd11, 1'b0, 8'h0C, 8'h00, 8'h5A},
    {4'd3,  1'b0, 8'h17, 8'h00, 8'hFF},
    {4'd3,  1'b0, 8'h1F, 8'h00, 8'hFF},
    {4'd3,  1'b0, 8'h30, 8'h00, 8'hFF},
    {4'd3,  1'b0, 8'hFF, 8'h00, 8'hFF}
  };

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%02h exp=%02h", tag, got, exp);
    end
  endtask

  task automatic wr_open(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    #1;
  endtask

  task automatic wr_close();
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic do_write(input logic [7:0] a, input logic [7:0] d);
    wr_open(a, d);
    wr_close();
  endtask

  task automatic do_read(input logic [7:0] a, output logic [7:0] v);
    @(negedge clk);
    addr = a;
    #1 v = rdata;
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    do_read(8'h16, v); check("R1 status", v, 8'h70);
    do_read(8'h14, v); check("R1 vol", v, 8'h00);
    do_read(8'h15, v); check("R1 pan", v, 8'h00);
    check("R1 power", 8'(pwr_on), 8'h00);

    // Table walk: R11 readback masks, R3 unmapped, R2 status
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][24]) do_write(VEC[i][23:16], VEC[i][15:8]);
      else begin
        do_read(VEC[i][23:16], v);
        check($sformatf("R%0d vec%0d", VEC[i][28:25], i), v, VEC[i][7:0]);
      end
    end

    // R2 live active bits
    act = 4'b1010;
    do_read(8'h16, v); check("R2 status live", v, 8'hFA);

    // R13 write visible only after the edge
    wr_open(8'h14, 8'h21);
    check("R13 old value", rdata, 8'h77);
    wr_close();
    do_read(8'h14, v); check("R13 new value", v, 8'h21);

    // R10 extra clock flag
    phase = 1'b0;
    wr_open(8'h09, 8'h80);
    check("R10 extra set", 8'(trig_extra), 8'h01);
    check("R10 ch strobe", 8'(ch_wr), 8'h02);
    check("R10 slot", 8'(ch_slot), 8'h04);
    wr_close();
    phase = 1'b1;
    wr_open(8'h09, 8'h80);
    check("R10 extra clear", 8'(trig_extra), 8'h00);
    wr_close();
    phase = 1'b0;
    wr_open(8'h0C, 8'h11);
    check("R10 non-trigger", 8'(trig_extra), 8'h00);
    wr_close();

    // R8 power off
    wr_open(8'h16, 8'h00);
    check("R8 clear pulse", 8'(pwr_clr), 8'h01);
    wr_close();
    do_read(8'h14, v); check("R8 vol", v, 8'h00);
    do_read(8'h15, v); check("R8 pan", v, 8'h00);
    do_read(8'h02, v); check("R8 env", v, 8'h00);
    do_read(8'h0C, v); check("R8 env ch1", v, 8'h00);
    do_read(8'h16, v); check("R2 status off", v, 8'h7A);

    // R5 writes ignored while off
    do_write(8'h14, 8'h77);
    do_read(8'h14, v); check("R5 vol ignored", v, 8'h00);
    wr_open(8'h02, 8'h33);
    check("R5 no strobe", 8'(ch_wr), 8'h00);
    wr_close();
    do_read(8'h02, v); check("R5 env ignored", v, 8'h00);

    // R4 wave write while off
    wr_open(8'h25, 8'h9C);
    check("R4 wave wr", 8'(wave_wr), 8'h01);
    check("R4 wave idx", 8'(wave_idx), 8'h05);
    check("R4 wave data", wave_wdata, 8'h9C);
    wr_close();

    // R12 wave read
    @(negedge clk);
    addr = 8'h2A; rd_en = 1'b1; wave_rdata = 8'h3C;
    #1;
    check("R12 wave data", rdata, 8'h3C);
    check("R12 wave rd", 8'(wave_rd), 8'h01);
    check("R12 wave idx", 8'(wave_idx), 8'h0A);
    rd_en = 1'b0;

    // R6 variant 0 length load while off
    variant = 1'b0;
    wr_open(8'h06, 8'h3F);
    check("R6 len load", 8'(len_load), 8'h02);
    check("R6 no ch strobe", 8'(ch_wr), 8'h00);
    wr_close();

    // R7 variant 1 rejects it
    variant = 1'b1;
    wr_open(8'h06, 8'h3F);
    check("R7 no len load", 8'(len_load), 8'h00);
    wr_close();

    // R9 power on, variant 1
    wr_open(8'h16, 8'h80);
    check("R9 restart v1", 8'(fs_rst), 8'h01);
    check("R9 len reset v1", 8'(len_rst), 8'h01);
    wr_close();
    do_read(8'h16, v); check("R4 status write off", v, 8'hFA);

    // R9 power on, variant 0
    variant = 1'b0;
    do_write(8'h16, 8'h00);
    wr_open(8'h16, 8'h80);
    check("R9 restart v0", 8'(fs_rst), 8'h01);
    check("R9 no len reset v0", 8'(len_rst), 8'h00);
    wr_close();

    done = 1'b1;
    summary();
    $finish;
  end

endmodule